// File: doc/BRIEF.md
# Multiprocessor Reservation Monitor

This block tracks load-locked reservations for a group of processor contexts sharing one memory request port. Each context owns one reservation slot holding a physical address and a valid flag. A locked read claims a reservation. A later conditional store from the same context either commits or is refused, depending on whether the claim is still intact. Any store that actually reaches memory removes every reservation covering the same 16-byte aligned block, whichever context holds it.

One request can be presented per cycle, together with the index of the issuing context. The registered response appears one cycle later. It carries a result code and a flag telling the memory side whether the store may be performed. Each context also counts its back-to-back conditional-store failures. When that count lands on a nonzero multiple of a configurable interval, the block emits a one-cycle livelock warning that names the context and gives the count.

Top module: `resv_monitor`

## Requirements
- R1: On reset, and after it, no response or warning is raised, every reservation flag is cleared (so a cacheable conditional store then fails) and every failure count is zero.
- R2: A request accepted in cycle t produces `rsp_valid` high in cycle t+1 only. `rsp_valid` is low in the cycle after an idle cycle.
- R3: A locked read (`req_write`=0, `req_locked`=1) from context c records its address as c's reservation and sets c's flag. Its response has code 3 and `rsp_mem_write`=0.
- R4: Reservation matching compares address bits [ADDR_W-1:4] only. Addresses in the same 16-byte aligned block match. Addresses differing in bit 4 or above do not.
- R5: A cacheable conditional store (`req_write`=1, `req_locked`=1, `req_uncached`=0) from c returns code 1 with `rsp_mem_write`=1 when c's flag is set and its address matches. Otherwise it returns code 0 with `rsp_mem_write`=0 and clears c's flag.
- R6: An uncacheable conditional store skips the reservation check, returns code 2 with `rsp_mem_write`=1 and resets the issuer's failure count to zero.
- R7: An ordinary store (`req_write`=1, `req_locked`=0) returns code 3 with `rsp_mem_write`=1. It clears the flag of every context whose reservation matches it.
- R8: A successful or uncacheable conditional store clears every matching reservation, its own included. A failed conditional store leaves other contexts' reservations untouched.
- R9: An ordinary read returns code 3 with `rsp_mem_write`=0 and changes no reservation.
- R10: Each failed cacheable conditional store increments the issuer's failure count, and a successful one resets it to zero. When the count becomes a nonzero multiple of WARN_INTERVAL, `warn_valid` pulses in the response cycle with `warn_cpu` and `warn_count` set to the issuer and its new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_cpu | input | CPU_W | Issuing context index |
| req_addr | input | ADDR_W | Physical address |
| req_write | input | 1 | 1 = store, 0 = read |
| req_locked | input | 1 | Locked read or conditional store qualifier |
| req_uncached | input | 1 | Uncacheable qualifier |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_code | output | 2 | 0 fail, 1 pass, 2 uncacheable conditional, 3 not conditional |
| rsp_mem_write | output | 1 | Store is allowed to reach memory |
| warn_valid | output | 1 | Livelock warning pulse |
| warn_cpu | output | CPU_W | Context that raised the warning |
| warn_count | output | CNT_W | Its consecutive failure count |

## Verification
Two functions meet in one cycle when a conditional store commits. The issuing context's own failure count resets and its own reservation clears through the same invalidation that removes other contexts' matching claims. A failing store is the other case: the failure increment can coincide with a warning pulse. The bench provokes both with directed sequences in which two contexts reserve the same block, one commits and the other then tries. It also runs a long stream of random requests over a few shared blocks with a small warning interval. A behavioural model of per-context flags, addresses and counts predicts the response code, the memory-write flag and the warning fields, and these are compared in every cycle.

// File: rtl/resv_monitor_pkg.sv
package resv_monitor_pkg;
    typedef enum logic [1:0] {
        RC_FAIL     = 2'd0,
        RC_PASS     = 2'd1,
        RC_UNCACHED = 2'd2,
        RC_NOT_COND = 2'd3
    } rsp_code_e;

    typedef struct packed {
        logic      valid;
        rsp_code_e code;
        logic      mem_write;
    } rsp_t;
endpackage

// File: rtl/resv_slot.sv
module resv_slot #(
    parameter int ADDR_W        = 32,
    parameter int GRAN_BITS     = 4,
    parameter int CNT_W         = 32,
    parameter int WARN_INTERVAL = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_mine,
    input  logic              i_write,
    input  logic              i_locked,
    input  logic              i_uncached,
    input  logic [ADDR_W-1:0] i_addr,
    input  logic              i_store_commit,
    output logic              o_resv_hit,
    output logic              o_warn,
    output logic [CNT_W-1:0]  o_fail_cnt
);
    localparam int PH_W = $clog2(WARN_INTERVAL + 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(WARN_INTERVAL - 1);

    typedef struct packed {
        logic              flag;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  fails;
        logic [PH_W-1:0]   phase;
        logic              warn;
    } slot_t;

    slot_t st_q, st_d;
    logic  blk_same;
    logic  lock_rd, cond_st;

    assign blk_same   = st_q.addr[ADDR_W-1:GRAN_BITS] == i_addr[ADDR_W-1:GRAN_BITS];
    assign o_resv_hit = st_q.flag && blk_same;
    assign lock_rd    = i_mine && !i_write && i_locked;
    assign cond_st    = i_mine && i_write && i_locked;
    assign o_warn     = st_q.warn;
    assign o_fail_cnt = st_q.fails;

    always_comb begin
        st_d      = st_q;
        st_d.warn = 1'b0;
        // invalidation first, then a new claim may overwrite it
        if (i_store_commit && blk_same)
            st_d.flag = 1'b0;
        if (lock_rd) begin
            st_d.flag = 1'b1;
            st_d.addr = i_addr;
        end
        if (cond_st) begin
            if (i_uncached || o_resv_hit) begin
                st_d.fails = '0;
                st_d.phase = '0;
            end else begin
                st_d.flag  = 1'b0;
                st_d.fails = st_q.fails + CNT_W'(1);
                if (st_q.phase == PH_LAST) begin
                    st_d.phase = '0;
                    st_d.warn  = 1'b1;
                end else begin
                    st_d.phase = st_q.phase + PH_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a locked read always leaves a live reservation
    p_claim_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lock_rd |=> st_q.flag);
    // R5: a refused conditional store drops the claim and counts
    p_refuse_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_st && !i_uncached && !o_resv_hit) |=>
        (!st_q.flag && st_q.fails == $past(st_q.fails) + CNT_W'(1)));
    // R7: a committed store in the same block kills the claim
    p_commit_kills_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (i_store_commit && blk_same && !lock_rd) |=> !st_q.flag);
    // R10: a warning never comes with a zero count
    p_warn_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.warn |-> st_q.fails != '0);
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_monitor_pkg::*;
#(
    parameter int NUM_CPU       = 4,
    parameter int ADDR_W        = 32,
    parameter int GRAN_BITS     = 4,
    parameter int CNT_W         = 32,
    parameter int WARN_INTERVAL = 100000,
    localparam int CPU_W        = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_locked,
    input  logic              req_uncached,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic              rsp_mem_write,
    output logic              warn_valid,
    output logic [CPU_W-1:0]  warn_cpu,
    output logic [CNT_W-1:0]  warn_count
);
    logic [NUM_CPU-1:0] mine, hit, warn_vec;
    logic [CNT_W-1:0]   cnt [NUM_CPU];
    logic               own_hit, commit;
    rsp_t               rsp_q, rsp_d;

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
        assign mine[g] = req_valid && (req_cpu == CPU_W'(g));
        resv_slot #(
            .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS),
            .CNT_W(CNT_W), .WARN_INTERVAL(WARN_INTERVAL)
        ) i_slot (
            .clk(clk), .rst_n(rst_n),
            .i_mine(mine[g]), .i_write(req_write), .i_locked(req_locked),
            .i_uncached(req_uncached), .i_addr(req_addr),
            .i_store_commit(commit),
            .o_resv_hit(hit[g]), .o_warn(warn_vec[g]), .o_fail_cnt(cnt[g])
        );
    end

    assign own_hit = |(mine & hit);
    assign commit  = req_valid && req_write &&
                     (!req_locked || req_uncached || own_hit);

    always_comb begin
        rsp_d.valid     = req_valid;
        rsp_d.mem_write = commit;
        if (!(req_write && req_locked)) rsp_d.code = RC_NOT_COND;
        else if (req_uncached)          rsp_d.code = RC_UNCACHED;
        else if (own_hit)               rsp_d.code = RC_PASS;
        else                            rsp_d.code = RC_FAIL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_code      = rsp_q.code;
    assign rsp_mem_write = rsp_q.mem_write;
    assign warn_valid    = |warn_vec;

    always_comb begin
        warn_cpu   = '0;
        warn_count = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (warn_vec[i]) begin
                warn_cpu   = CPU_W'(i);
                warn_count = cnt[i];
            end
        end
    end

    // R2: one response per request, exactly one cycle later
    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R5: a refused conditional store never reaches memory
    p_fail_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RC_FAIL) |-> !rsp_mem_write);
    // R6: an uncacheable conditional store always writes
    p_uncached_writes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RC_UNCACHED) |-> rsp_mem_write);
    // R9: a non-conditional access writes exactly when it was a store
    p_plain_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RC_NOT_COND) |-> rsp_mem_write == $past(req_write));
    // R10: warnings come from one context, with a refused store
    p_warn_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(warn_vec));
    p_warn_on_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        warn_valid |-> (rsp_valid && rsp_code == RC_FAIL));
endmodule

// File: tb/test_resv_monitor.sv
`timescale 1ns/1ps
module test_resv_monitor;
    localparam int NCPU = 4;
    localparam int AW   = 32;
    localparam int CW   = 32;
    localparam int IVL  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_cpu = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0, req_locked = 1'b0, req_uncached = 1'b0;
    logic          rsp_valid, rsp_mem_write, warn_valid;
    logic [1:0]    rsp_code, warn_cpu;
    logic [CW-1:0] warn_count;

    always #2 clk = ~clk;

    resv_monitor #(.NUM_CPU(NCPU), .ADDR_W(AW), .GRAN_BITS(4), .CNT_W(CW),
                   .WARN_INTERVAL(IVL)) i_resv_monitor (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cpu(req_cpu),
        .req_addr(req_addr), .req_write(req_write), .req_locked(req_locked),
        .req_uncached(req_uncached), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_mem_write(rsp_mem_write), .warn_valid(warn_valid),
        .warn_cpu(warn_cpu), .warn_count(warn_count));

    int checks = 0, errors = 0;
    bit            m_flag [NCPU];
    logic [AW-1:0] m_addr [NCPU];
    int            m_fail [NCPU];
    bit            e_valid, e_mw, e_warn;
    int            e_code, e_wcpu, e_wcnt;
    string         e_tag = "R1";

    function automatic bit same_blk(logic [AW-1:0] a, logic [AW-1:0] b);
        return (a >> 4) == (b >> 4);
    endfunction

    task automatic compare();
        bit bad;
        checks++;
        bad = (rsp_valid !== e_valid) || (warn_valid !== e_warn);
        if (e_valid && (rsp_code !== 2'(e_code) || rsp_mem_write !== e_mw)) bad = 1;
        if (e_warn && (warn_cpu !== 2'(e_wcpu) || warn_count !== CW'(e_wcnt))) bad = 1;
        if (bad) begin
            errors++;
            $display("FAIL %s: got v=%0b code=%0d mw=%0b warn=%0b cpu=%0d cnt=%0d; expected v=%0b code=%0d mw=%0b warn=%0b cpu=%0d cnt=%0d",
                     e_tag, rsp_valid, rsp_code, rsp_mem_write, warn_valid, warn_cpu,
                     warn_count, e_valid, e_code, e_mw, e_warn, e_wcpu, e_wcnt);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NCPU; i++) begin
            m_flag[i] = 0; m_addr[i] = '0; m_fail[i] = 0;
        end
    endtask

    task automatic step(bit v, int c, logic [AW-1:0] a, bit w, bit lk, bit uc, string tag);
        @(negedge clk);
        compare();
        req_valid = v; req_cpu = 2'(c); req_addr = a;
        req_write = w; req_locked = lk; req_uncached = uc;
        e_valid = v; e_warn = 0; e_mw = 0; e_code = 3; e_tag = tag;
        if (v) begin
            if (w && lk && uc) begin
                e_code = 2; e_mw = 1; m_fail[c] = 0;
            end else if (w && lk) begin
                if (m_flag[c] && same_blk(m_addr[c], a)) begin
                    e_code = 1; e_mw = 1; m_fail[c] = 0;
                end else begin
                    e_code = 0; m_flag[c] = 0; m_fail[c]++;
                    if (m_fail[c] % IVL == 0) begin
                        e_warn = 1; e_wcpu = c; e_wcnt = m_fail[c];
                    end
                end
            end else if (w) begin
                e_mw = 1;
            end
            if (e_mw)
                for (int j = 0; j < NCPU; j++)
                    if (same_blk(m_addr[j], a)) m_flag[j] = 0;
            if (!w && lk) begin
                m_flag[c] = 1; m_addr[c] = a;
            end
        end
    endtask

    task automatic idle(string tag); step(0, 0, '0, 0, 0, 0, tag); endtask
    task automatic ll(int c, logic [AW-1:0] a, string t);  step(1, c, a, 0, 1, 0, t); endtask
    task automatic sc(int c, logic [AW-1:0] a, string t);  step(1, c, a, 1, 1, 0, t); endtask
    task automatic scu(int c, logic [AW-1:0] a, string t); step(1, c, a, 1, 1, 1, t); endtask
    task automatic st(int c, logic [AW-1:0] a, string t);  step(1, c, a, 1, 0, 0, t); endtask
    task automatic ld(int c, logic [AW-1:0] a, string t);  step(1, c, a, 0, 0, 0, t); endtask

    task automatic do_reset();
        @(negedge clk);
        compare();
        rst_n = 0; req_valid = 0;
        model_clear();
        e_valid = 0; e_warn = 0; e_tag = "R1";
        repeat (2) @(negedge clk);
        compare();
        rst_n = 1;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        e_valid = 0; e_warn = 0; e_code = 3; e_mw = 0; e_wcpu = 0; e_wcnt = 0;
        repeat (3) @(negedge clk);
        compare();                       // R1 outputs quiet in reset
        rst_n = 1;
        idle("R1");
        sc(0, 32'h40, "R1");             // no reservation after reset
        idle("R2");
        // R3 / R4 granularity
        ll(0, 32'h1004, "R3");
        sc(0, 32'h100C, "R4");           // same block -> pass
        ll(1, 32'h2000, "R3");
        sc(1, 32'h2010, "R4");           // bit 4 differs -> fail
        sc(1, 32'h2000, "R5");           // flag cleared by the failure
        // R8 commit kills others; failed store does not
        ll(0, 32'h3000, "R3");
        ll(1, 32'h3008, "R3");
        sc(0, 32'h300F, "R8");
        sc(1, 32'h3000, "R8");
        ll(2, 32'h4000, "R3");
        sc(3, 32'h4000, "R8");
        sc(2, 32'h4000, "R8");
        // R7 ordinary store
        ll(0, 32'h5000, "R3");
        st(1, 32'h5004, "R7");
        sc(0, 32'h5000, "R7");
        ll(0, 32'h5000, "R3");
        st(1, 32'h5010, "R7");
        sc(0, 32'h5000, "R7");
        // R9 ordinary read
        ll(0, 32'h6000, "R3");
        ld(1, 32'h6000, "R9");
        sc(0, 32'h6000, "R9");
        // R6 uncacheable conditional
        sc(2, 32'h7100, "R10");
        sc(2, 32'h7100, "R10");
        ll(1, 32'h7000, "R3");
        scu(2, 32'h7004, "R6");
        sc(1, 32'h7000, "R6");
        sc(2, 32'h7100, "R6");
        sc(2, 32'h7100, "R6");
        sc(2, 32'h7100, "R6");           // warn at count 3 after reset
        // R10 periodic warnings
        for (int k = 0; k < 7; k++) sc(3, 32'h8000, "R10");
        ll(3, 32'h8000, "R3");
        sc(3, 32'h8000, "R10");
        for (int k = 0; k < 3; k++) sc(3, 32'h8000, "R10");
        idle("R2");
        idle("R2");
        // R1 mid-run reset
        ll(0, 32'h100, "R3");
        do_reset();
        idle("R1");
        sc(0, 32'h100, "R1");
        // random traffic over a few shared blocks
        for (int n = 0; n < 600; n++) begin
            logic [AW-1:0] a;
            int kind, c;
            c    = int'($urandom_range(0, NCPU - 1));
            a    = 32'h9000 + 32'($urandom_range(0, 3)) * 32'h10 + 32'($urandom_range(0, 15));
            kind = int'($urandom_range(0, 9));
            case (kind)
                0, 1, 2: ll(c, a, "R3");
                3, 4, 5: sc(c, a, "R5");
                6:       scu(c, a, "R6");
                7:       st(c, a, "R7");
                8:       ld(c, a, "R9");
                default: idle("R2");
            endcase
        end
        idle("R2");
        idle("R2");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule